// File: doc/BRIEF.md
# Interprocessor interrupt destination matcher

This block sits at the message input of one core's interrupt controller. Each cycle it may receive one interprocessor interrupt message. The message carries a destination byte, a physical or logical addressing flag, a two-bit shorthand, a delivery mode, a trigger mode and a level bit. The block compares the message against the core's own identity. That identity is its physical ID, its logical ID, and whether logical addressing uses the flat or the cluster format. One cycle later the block reports whether the message is aimed at this core.

The block also tracks the core's startup handshake. An accepted INIT message parks the core in a wait-for-startup state. A later startup message returns it to normal operation. A startup message that arrives while the core is not waiting is dropped.

Choosing a winner among several candidates for lowest-priority delivery is done elsewhere. Queuing the vector is also done elsewhere.

Top module: `ipi_dest_match`

## Requirements
- R1: After reset, matchValid, matchOut and waitStartup are all 0.
- R2: Sampling msgValid=1 at a clock edge makes matchValid 1 for exactly the following cycle, with matchOut holding the decision for that message. With no message, matchValid and matchOut are 0.
- R3: With shorthand 2'b00 and msgLogical=0 (physical), the message matches when msgDest equals cfgApicId, or when msgDest is 8'hFF (broadcast).
- R4: With shorthand 2'b00, msgLogical=1 and cfgClusterFmt=0 (flat), the message matches when cfgLogicalId AND msgDest is nonzero.
- R5: With shorthand 2'b00, msgLogical=1 and cfgClusterFmt=1 (cluster), the message matches when the low nibbles of cfgLogicalId and msgDest are equal and the AND of their high nibbles is nonzero.
- R6: The shorthand overrides the destination. 2'b01 matches only when msgFromSelf=1. 2'b10 always matches. 2'b11 matches only when msgFromSelf=0.
- R7: Delivery mode 3'b001 (lowest priority) with msgLogical=0 never matches, whatever the shorthand.
- R8: A matched INIT message (delivery 3'b101) sets waitStartup to 1 in the cycle after it is sampled, unless R9 applies.
- R9: An INIT message with msgLevelTrig=1 and msgAssert=0 is ignored. waitStartup keeps its value, although matchOut still reports the address match.
- R10: A matched startup message (delivery 3'b110) clears waitStartup when it is 1, and leaves it at 0 when it is 0. Messages that do not match, and messages of other delivery modes, leave waitStartup unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | A message is presented this cycle |
| msgDest | input | 8 | Destination byte |
| msgLogical | input | 1 | 1 = logical addressing, 0 = physical |
| msgShort | input | 2 | Shorthand: 00 none, 01 self, 10 all, 11 all but self |
| msgDelivery | input | 3 | Delivery mode: 000 fixed, 001 lowest, 100 NMI, 101 INIT, 110 startup |
| msgLevelTrig | input | 1 | 1 = level triggered |
| msgAssert | input | 1 | Level bit, 1 = asserted |
| msgFromSelf | input | 1 | The message was sent by this core |
| cfgApicId | input | 8 | This core's physical ID |
| cfgLogicalId | input | 8 | This core's logical ID |
| cfgClusterFmt | input | 1 | Logical format: 0 flat, 1 cluster |
| matchValid | output | 1 | matchOut is valid this cycle |
| matchOut | output | 1 | The last message targets this core |
| waitStartup | output | 1 | The core is waiting for a startup message |

## Verification
The assertions check several rules on every cycle:
- Physical lowest-priority messages never match.
- Both broadcast shorthands and self-only messages from other cores give their fixed result.
- matchOut is never high without matchValid.
- The handshake state moves only on an accepted INIT or startup message.

The flat and cluster comparisons, and the exact physical ID compare, depend on the configured identities. Only the bench's directed and random scenarios can show these, checked against its own model. The same holds for the ignored deasserted INIT and the dropped startup in the normal state.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DLV_W = 3;
  localparam logic [DLV_W-1:0] DLV_FIXED   = 3'b000;
  localparam logic [DLV_W-1:0] DLV_LOWEST  = 3'b001;
  localparam logic [DLV_W-1:0] DLV_NMI     = 3'b100;
  localparam logic [DLV_W-1:0] DLV_INIT    = 3'b101;
  localparam logic [DLV_W-1:0] DLV_STARTUP = 3'b110;

  localparam logic [1:0] SH_NONE     = 2'b00;
  localparam logic [1:0] SH_SELF     = 2'b01;
  localparam logic [1:0] SH_ALL      = 2'b10;
  localparam logic [1:0] SH_ALL_XSELF = 2'b11;

  typedef enum logic {HS_NORMAL = 1'b0, HS_WAIT = 1'b1} hsState_t;

  // Strobes from the match datapath to the handshake control.
  typedef struct packed {
    logic hit;
    logic initReq;
    logic startupReq;
  } msgStrobe_t;
endpackage

// File: rtl/ipi_match_dp.sv
module ipi_match_dp
  import ipi_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  input  logic [ID_W-1:0]  msgDest,
  input  logic             msgLogical,
  input  logic [1:0]       msgShort,
  input  logic [DLV_W-1:0] msgDelivery,
  input  logic             msgLevelTrig,
  input  logic             msgAssert,
  input  logic             msgFromSelf,
  input  logic [ID_W-1:0]  cfgApicId,
  input  logic [ID_W-1:0]  cfgLogicalId,
  input  logic             cfgClusterFmt,
  output msgStrobe_t       strobes,
  output logic             matchValid,
  output logic             matchOut
);
  localparam int HALF = ID_W / 2;
  localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

  logic physHit, flatHit, clusterHit, destHit, shortHit, blocked, hit;

  assign physHit = (msgDest == cfgApicId) || (msgDest == BCAST);
  assign flatHit = |(cfgLogicalId & msgDest);

  generate
    if (HALF > 0) begin : g_cluster
      logic lowEq, highAny;
      assign lowEq   = cfgLogicalId[HALF-1:0] == msgDest[HALF-1:0];
      assign highAny = |(cfgLogicalId[ID_W-1:HALF] & msgDest[ID_W-1:HALF]);
      assign clusterHit = lowEq && highAny;
    end else begin : g_nocluster
      assign clusterHit = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!msgLogical)       destHit = physHit;
    else if (cfgClusterFmt) destHit = clusterHit;
    else                    destHit = flatHit;
  end

  always_comb begin
    unique case (msgShort)
      SH_NONE:  shortHit = destHit;
      SH_SELF:  shortHit = msgFromSelf;
      SH_ALL:   shortHit = 1'b1;
      default:  shortHit = !msgFromSelf;
    endcase
  end

  assign blocked = !msgLogical && (msgDelivery == DLV_LOWEST);
  assign hit     = shortHit && !blocked;

  always_comb begin
    strobes.hit        = msgValid && hit;
    strobes.initReq    = msgValid && hit && (msgDelivery == DLV_INIT)
                         && !(msgLevelTrig && !msgAssert);
    strobes.startupReq = msgValid && hit && (msgDelivery == DLV_STARTUP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchValid <= 1'b0;
      matchOut   <= 1'b0;
    end else begin
      matchValid <= msgValid;
      matchOut   <= msgValid && hit;
    end
  end

  assert_lowest_phys_R7: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgLogical && msgDelivery == DLV_LOWEST) |=> !matchOut);

  assert_bcast_all_R6: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgShort == SH_ALL && !(!msgLogical && msgDelivery == DLV_LOWEST))
      |=> matchOut);

  assert_excl_self_R6: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgShort == SH_ALL_XSELF && msgFromSelf) |=> !matchOut);

  assert_self_other_R6: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgShort == SH_SELF && !msgFromSelf) |=> !matchOut);

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    matchOut |-> matchValid);
endmodule

// File: rtl/ipi_handshake_ctl.sv
module ipi_handshake_ctl
  import ipi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  msgStrobe_t strobes,
  output logic       waitStartup
);
  hsState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      HS_NORMAL: if (strobes.initReq) stateNext = HS_WAIT;
      HS_WAIT:   if (strobes.startupReq) stateNext = HS_NORMAL;
      default:   stateNext = HS_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= HS_NORMAL;
    else       state <= stateNext;
  end

  assign waitStartup = (state == HS_WAIT);

  assert_init_wait_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.initReq |=> waitStartup);

  assert_startup_leave_R10: assert property (@(posedge clk) disable iff (!rstN)
    (waitStartup && strobes.startupReq) |=> !waitStartup);

  assert_state_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.initReq && !strobes.startupReq) |=> $stable(waitStartup));
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  input  logic [ID_W-1:0]  msgDest,
  input  logic             msgLogical,
  input  logic [1:0]       msgShort,
  input  logic [DLV_W-1:0] msgDelivery,
  input  logic             msgLevelTrig,
  input  logic             msgAssert,
  input  logic             msgFromSelf,
  input  logic [ID_W-1:0]  cfgApicId,
  input  logic [ID_W-1:0]  cfgLogicalId,
  input  logic             cfgClusterFmt,
  output logic             matchValid,
  output logic             matchOut,
  output logic             waitStartup
);
  msgStrobe_t strobes;

  ipi_match_dp #(.ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgDest(msgDest),
    .msgLogical(msgLogical), .msgShort(msgShort), .msgDelivery(msgDelivery),
    .msgLevelTrig(msgLevelTrig), .msgAssert(msgAssert),
    .msgFromSelf(msgFromSelf), .cfgApicId(cfgApicId),
    .cfgLogicalId(cfgLogicalId), .cfgClusterFmt(cfgClusterFmt),
    .strobes(strobes), .matchValid(matchValid), .matchOut(matchOut)
  );

  ipi_handshake_ctl u_ctl (
    .clk(clk), .rstN(rstN), .strobes(strobes), .waitStartup(waitStartup)
  );
endmodule

// File: tb/tb_ipi_dest_match.sv
module tb_ipi_dest_match;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msgValid = 0, msgLogical = 0, msgLevelTrig = 0, msgAssert = 0;
  logic msgFromSelf = 0, cfgClusterFmt = 0;
  logic [7:0] msgDest = 0, cfgApicId = 0, cfgLogicalId = 0;
  logic [1:0] msgShort = 0;
  logic [2:0] msgDelivery = 0;
  logic matchValid, matchOut, waitStartup;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit modelWait = 0;

  always #10 clk = ~clk;

  ipi_dest_match dut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgDest(msgDest),
    .msgLogical(msgLogical), .msgShort(msgShort), .msgDelivery(msgDelivery),
    .msgLevelTrig(msgLevelTrig), .msgAssert(msgAssert),
    .msgFromSelf(msgFromSelf), .cfgApicId(cfgApicId),
    .cfgLogicalId(cfgLogicalId), .cfgClusterFmt(cfgClusterFmt),
    .matchValid(matchValid), .matchOut(matchOut), .waitStartup(waitStartup)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit modelHit(logic [7:0] d, bit lg, logic [1:0] sh,
                                  logic [2:0] dl, bit fs);
    bit r;
    if (!lg && dl == 3'b001) return 0;
    case (sh)
      2'b01: r = fs;
      2'b10: r = 1;
      2'b11: r = !fs;
      default: begin
        if (!lg) r = (d == cfgApicId) || (d == 8'hFF);
        else if (cfgClusterFmt)
          r = (d[3:0] == cfgLogicalId[3:0]) && ((d[7:4] & cfgLogicalId[7:4]) != 0);
        else r = (d & cfgLogicalId) != 0;
      end
    endcase
    return r;
  endfunction

  task automatic send(string req, logic [7:0] d, bit lg, logic [1:0] sh,
                      logic [2:0] dl, bit lt, bit as, bit fs);
    bit eh;
    @(negedge clk);
    eh = modelHit(d, lg, sh, dl, fs);
    msgDest = d; msgLogical = lg; msgShort = sh; msgDelivery = dl;
    msgLevelTrig = lt; msgAssert = as; msgFromSelf = fs; msgValid = 1;
    if (eh && dl == 3'b101 && !(lt && !as)) modelWait = 1;
    else if (eh && dl == 3'b110) modelWait = 0;
    @(negedge clk);
    msgValid = 0;
    check({req, " matchValid"}, matchValid, 1);
    check({req, " matchOut"}, matchOut, eh);
    check({req, " waitStartup"}, waitStartup, modelWait);
  endtask

  task automatic setCfg(logic [7:0] id, logic [7:0] lid, bit cl);
    @(negedge clk);
    cfgApicId = id; cfgLogicalId = lid; cfgClusterFmt = cl;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 matchValid", matchValid, 0);
    check("R1 matchOut", matchOut, 0);
    check("R1 waitStartup", waitStartup, 0);
    rstN = 1;
    setCfg(8'h05, 8'h24, 0);

    send("R3 phys exact", 8'h05, 0, 2'b00, 3'b000, 0, 1, 0);
    send("R3 phys other", 8'h06, 0, 2'b00, 3'b000, 0, 1, 0);
    send("R3 phys bcast", 8'hFF, 0, 2'b00, 3'b000, 0, 1, 0);
    @(negedge clk);
    check("R2 idle matchValid", matchValid, 0);
    check("R2 idle matchOut", matchOut, 0);
    send("R4 flat hit", 8'h04, 1, 2'b00, 3'b000, 0, 1, 0);
    send("R4 flat miss", 8'h81, 1, 2'b00, 3'b000, 0, 1, 0);
    setCfg(8'h05, 8'h23, 1);
    send("R5 cluster hit", 8'h33, 1, 2'b00, 3'b000, 0, 1, 0);
    send("R5 cluster low miss", 8'h32, 1, 2'b00, 3'b000, 0, 1, 0);
    send("R5 cluster high miss", 8'hD3, 1, 2'b00, 3'b000, 0, 1, 0);
    send("R6 self from self", 8'h00, 0, 2'b01, 3'b000, 0, 1, 1);
    send("R6 self from other", 8'h05, 0, 2'b01, 3'b000, 0, 1, 0);
    send("R6 all", 8'h00, 0, 2'b10, 3'b000, 0, 1, 1);
    send("R6 allx self", 8'h05, 0, 2'b11, 3'b000, 0, 1, 1);
    send("R6 allx other", 8'h00, 0, 2'b11, 3'b000, 0, 1, 0);
    send("R7 lowest phys", 8'h05, 0, 2'b00, 3'b001, 0, 1, 0);
    send("R7 lowest phys all", 8'h05, 0, 2'b10, 3'b001, 0, 1, 0);
    send("R10 startup in normal", 8'h05, 0, 2'b00, 3'b110, 0, 1, 0);
    send("R9 init deassert", 8'h05, 0, 2'b00, 3'b101, 1, 0, 0);
    send("R8 init miss", 8'h09, 0, 2'b00, 3'b101, 0, 1, 0);
    send("R8 init accept", 8'h05, 0, 2'b00, 3'b101, 0, 0, 0);
    send("R10 fixed no effect", 8'h05, 0, 2'b00, 3'b000, 0, 1, 0);
    send("R10 startup miss", 8'h07, 0, 2'b00, 3'b110, 0, 1, 0);
    send("R10 startup leave", 8'h05, 0, 2'b00, 3'b110, 0, 1, 0);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] d;
      logic [2:0] dl;
      if (i % 50 == 0) setCfg($urandom, $urandom, $urandom % 2);
      d = ($urandom % 3 == 0) ? (($urandom % 2) ? cfgApicId : cfgLogicalId) : $urandom;
      case ($urandom % 5)
        0: dl = 3'b000; 1: dl = 3'b001; 2: dl = 3'b100;
        3: dl = 3'b101; default: dl = 3'b110;
      endcase
      send("R3 R4 R5 R6 R8 R10 random", d, $urandom % 2,
           ($urandom % 3 == 0) ? 2'($urandom) : 2'b00,
           dl, $urandom % 2, $urandom % 2, $urandom % 2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule